// File: doc/BRIEF.md
# Segment Address Translator with Access Protection

This block turns a segmented virtual reference into a real memory address. A reference carries a segment number, a displacement inside that segment and the kind of access being attempted: read, write, execute or append. The block computes where the descriptor for that segment lives, which is the table origin plus the segment number. It then issues a single read on an external descriptor table port and, from the returned descriptor, produces either a real address or a fault.

Each descriptor holds four things: a presence flag, an upper bound on the displacement, four permission bits and the segment's base address. The real address is the base plus the displacement, added rather than concatenated, so segments may start anywhere. The presence flag, the bound and the permission bits are all examined in the same pass. At most one fault is reported, chosen by a fixed priority. The block accepts one reference per cycle and answers two cycles after each one.

Top module: `seg_xlate_unit`

## Requirements
- R1: In the cycle a reference is presented (`req_valid`=1), `tbl_rd_en` is 1 and `tbl_rd_addr` equals `tbl_base + req_seg` modulo 2^TBL_AW. `tbl_rd_en` is 0 in cycles with no reference. The table answers on `tbl_rd_data` one cycle after the read.
- R2: Every reference gets exactly one response, with `rsp_valid`=1 two clock cycles after the cycle in which it was presented. `rsp_valid` is 0 in every other cycle.
- R3: Descriptor layout, with the default widths: bits [15:0] hold the base, [27:16] the bound, [31:28] the permissions and bit 32 the presence flag. When no fault applies, `rsp_fault`=00 and `rsp_addr` = base + displacement modulo 2^ADDR_W.
- R4: If the presence flag (bit 32) is 0, `rsp_fault`=01 (missing), whatever the displacement and access kind are.
- R5: If the segment is present and the displacement is strictly greater than the bound, `rsp_fault`=10 (overflow). A displacement equal to the bound is in range.
- R6: Access kinds are encoded 00 read, 01 write, 10 execute and 11 append. Each kind is allowed by permission bit 28, 29, 30 or 31 respectively. If the segment is present and in range but the bit for the requested kind is 0, `rsp_fault`=11 (protection).
- R7: When several faults apply, only the highest one is reported, in the order missing, then overflow, then protection.
- R8: Whenever `rsp_fault` is non-zero, `rsp_addr` is 0.
- R9: While `rst_n` is low, `rsp_valid`, `rsp_fault` and `rsp_addr` are 0.
- R10: In cycles with `rsp_valid`=0, `rsp_fault` and `rsp_addr` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A reference is presented this cycle |
| req_seg | input | SEG_W | Segment number |
| req_disp | input | DISP_W | Displacement within the segment |
| req_kind | input | 2 | Access kind (00 read, 01 write, 10 execute, 11 append) |
| tbl_base | input | TBL_AW | Origin of the descriptor table |
| tbl_rd_en | output | 1 | Descriptor table read strobe |
| tbl_rd_addr | output | TBL_AW | Descriptor table read index |
| tbl_rd_data | input | ADDR_W+DISP_W+5 | Descriptor returned one cycle after the read |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 2 | 00 none, 01 missing, 10 overflow, 11 protection |
| rsp_addr | output | ADDR_W | Real address, zero when faulted or idle |

## Verification
The hardest outcomes to reach from the ports are the exact bound edge, where the displacement equals the bound or is one above it, and references that break several rules at once. With uniform random values these occur almost never. The bench therefore reads the descriptor it has just placed in its table model and draws the displacement within one of that descriptor's bound for half of the random references. It also writes directed descriptors that combine absence, excess and a missing permission, which exercises the priority order. A table origin near the top of the index range makes the descriptor index wrap around, and a base near the top of the address range makes the real address wrap.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    ACC_READ   = 2'b00,
    ACC_WRITE  = 2'b01,
    ACC_EXEC   = 2'b10,
    ACC_APPEND = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE     = 2'b00,
    FLT_MISSING  = 2'b01,
    FLT_OVERFLOW = 2'b10,
    FLT_PROTECT  = 2'b11
  } fault_e;

  localparam int unsigned NUM_KINDS = 4;

  // Picks the single fault to report, highest priority first.
  function automatic fault_e pick_fault(input logic present,
                                        input logic beyond,
                                        input logic permitted);
    if (!present)       return FLT_MISSING;
    else if (beyond)    return FLT_OVERFLOW;
    else if (!permitted) return FLT_PROTECT;
    else                return FLT_NONE;
  endfunction

endpackage

// File: rtl/seg_tbl_fetch.sv
module seg_tbl_fetch #(
  parameter int SEG_W  = 4,
  parameter int DISP_W = 12,
  parameter int TBL_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [DISP_W-1:0] req_disp,
  input  logic [1:0]        req_kind,
  input  logic [TBL_AW-1:0] tbl_base,
  output logic              rd_en,
  output logic [TBL_AW-1:0] rd_addr,
  output logic              s1_valid,
  output logic [DISP_W-1:0] s1_disp,
  output logic [1:0]        s1_kind
);

  // Descriptor index: table origin plus segment number, wrapping.
  function automatic logic [TBL_AW-1:0] desc_index(input logic [TBL_AW-1:0] origin,
                                                   input logic [SEG_W-1:0]  seg);
    return origin + TBL_AW'(seg);
  endfunction

  assign rd_en   = req_valid;
  assign rd_addr = desc_index(tbl_base, req_seg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_disp  <= '0;
      s1_kind  <= 2'b00;
    end else begin
      s1_valid <= req_valid;
      if (req_valid) begin
        s1_disp <= req_disp;
        s1_kind <= req_kind;
      end
    end
  end

endmodule

// File: rtl/seg_entry_decode.sv
module seg_entry_decode #(
  parameter int ADDR_W = 16,
  parameter int DISP_W = 12
) (
  input  logic [ADDR_W+DISP_W+4:0] entry,
  output logic [ADDR_W-1:0]        base,
  output logic [DISP_W-1:0]        bound,
  output logic [3:0]               perm,
  output logic                     present
);

  localparam int BOUND_LO = ADDR_W;
  localparam int PERM_LO  = ADDR_W + DISP_W;
  localparam int PRES_BIT = ADDR_W + DISP_W + 4;

  assign base    = entry[ADDR_W-1:0];
  assign bound   = entry[BOUND_LO +: DISP_W];
  assign perm    = entry[PERM_LO +: 4];
  assign present = entry[PRES_BIT];

endmodule

// File: rtl/seg_fault_check.sv
module seg_fault_check
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DISP_W = 12
) (
  input  logic              present,
  input  logic [DISP_W-1:0] bound,
  input  logic [3:0]        perm,
  input  logic [ADDR_W-1:0] base,
  input  logic [DISP_W-1:0] disp,
  input  logic [1:0]        kind,
  output fault_e            fault,
  output logic [ADDR_W-1:0] real_addr,
  output logic              beyond,
  output logic              permitted
);

  function automatic logic exceeds(input logic [DISP_W-1:0] d,
                                   input logic [DISP_W-1:0] lim);
    return d > lim;
  endfunction

  function automatic logic [ADDR_W-1:0] relocate(input logic [ADDR_W-1:0] b,
                                                 input logic [DISP_W-1:0] d);
    return b + ADDR_W'(d);
  endfunction

  logic [NUM_KINDS-1:0] kind_hit;

  for (genvar i = 0; i < NUM_KINDS; i++) begin : g_perm
    assign kind_hit[i] = perm[i] && (kind == 2'(i));
  end

  assign permitted = |kind_hit;
  assign beyond    = exceeds(disp, bound);
  assign fault     = pick_fault(present, beyond, permitted);
  assign real_addr = relocate(base, disp);

endmodule

// File: rtl/seg_rsp_stage.sv
module seg_rsp_stage
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  fault_e            in_fault,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  output logic [1:0]        out_fault,
  output logic [ADDR_W-1:0] out_addr
);

  logic clean;
  assign clean = in_valid && (in_fault == FLT_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_fault <= 2'b00;
      out_addr  <= '0;
    end else begin
      out_valid <= in_valid;
      out_fault <= in_valid ? in_fault : FLT_NONE;
      out_addr  <= clean ? in_addr : '0;
    end
  end

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W  = 4,
  parameter int DISP_W = 12,
  parameter int ADDR_W = 16,
  parameter int TBL_AW = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [SEG_W-1:0]         req_seg,
  input  logic [DISP_W-1:0]        req_disp,
  input  logic [1:0]               req_kind,
  input  logic [TBL_AW-1:0]        tbl_base,
  output logic                     tbl_rd_en,
  output logic [TBL_AW-1:0]        tbl_rd_addr,
  input  logic [ADDR_W+DISP_W+4:0] tbl_rd_data,
  output logic                     rsp_valid,
  output logic [1:0]               rsp_fault,
  output logic [ADDR_W-1:0]        rsp_addr
);

  logic              s1_valid;
  logic [DISP_W-1:0] s1_disp;
  logic [1:0]        s1_kind;
  logic [ADDR_W-1:0] s1_base;
  logic [DISP_W-1:0] s1_len;
  logic [3:0]        s1_perm;
  logic              s1_resident;
  fault_e            s1_fault;
  logic [ADDR_W-1:0] s1_real;
  logic              s1_beyond;
  logic              s1_permitted;

  seg_tbl_fetch #(.SEG_W(SEG_W), .DISP_W(DISP_W), .TBL_AW(TBL_AW)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_seg   (req_seg),
    .req_disp  (req_disp),
    .req_kind  (req_kind),
    .tbl_base  (tbl_base),
    .rd_en     (tbl_rd_en),
    .rd_addr   (tbl_rd_addr),
    .s1_valid  (s1_valid),
    .s1_disp   (s1_disp),
    .s1_kind   (s1_kind)
  );

  seg_entry_decode #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_decode (
    .entry   (tbl_rd_data),
    .base    (s1_base),
    .bound   (s1_len),
    .perm    (s1_perm),
    .present (s1_resident)
  );

  seg_fault_check #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_check (
    .present   (s1_resident),
    .bound     (s1_len),
    .perm      (s1_perm),
    .base      (s1_base),
    .disp      (s1_disp),
    .kind      (s1_kind),
    .fault     (s1_fault),
    .real_addr (s1_real),
    .beyond    (s1_beyond),
    .permitted (s1_permitted)
  );

  seg_rsp_stage #(.ADDR_W(ADDR_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (s1_valid),
    .in_fault  (s1_fault),
    .in_addr   (s1_real),
    .out_valid (rsp_valid),
    .out_fault (rsp_fault),
    .out_addr  (rsp_addr)
  );

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int ADDR_W = 16,
  parameter int DISP_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              s1_valid,
  input logic              s1_resident,
  input logic [DISP_W-1:0] s1_disp,
  input logic [DISP_W-1:0] s1_len,
  input logic              s1_beyond,
  input logic              s1_permitted,
  input logic              rsp_valid,
  input logic [1:0]        rsp_fault,
  input logic [ADDR_W-1:0] rsp_addr
);

  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ##1 rsp_valid);

  assert_no_rsp_without_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ##1 !rsp_valid);

  assert_missing_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_resident) |=> (rsp_fault == 2'b01));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_resident && (s1_disp > s1_len)) |=> (rsp_fault == 2'b10));

  assert_denied_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_resident && !s1_beyond && !s1_permitted) |=> (rsp_fault == 2'b11));

  assert_fault_zero_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_fault != 2'b00)) |-> (rsp_addr == '0));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> ((rsp_fault == 2'b00) && (rsp_addr == '0)));

endmodule

bind seg_xlate_unit seg_xlate_chk #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .s1_valid     (s1_valid),
  .s1_resident  (s1_resident),
  .s1_disp      (s1_disp),
  .s1_len       (s1_len),
  .s1_beyond    (s1_beyond),
  .s1_permitted (s1_permitted),
  .rsp_valid    (rsp_valid),
  .rsp_fault    (rsp_fault),
  .rsp_addr     (rsp_addr)
);

// File: tb/test_seg_xlate_unit.sv
module test_seg_xlate_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_seg = '0;
  logic [11:0] req_disp = '0;
  logic [1:0]  req_kind = '0;
  logic [7:0]  tbl_base = '0;
  logic        tbl_rd_en;
  logic [7:0]  tbl_rd_addr;
  logic [32:0] tbl_rd_data = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_fault;
  logic [15:0] rsp_addr;

  logic [32:0] mem [256];

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // Expected-response pipe: slot 0 is the newest request, slot 1 the oldest.
  logic        pv [2];
  logic [1:0]  pf [2];
  logic [15:0] pa [2];
  string       pt [2];

  always #10 clk = ~clk;

  always @(posedge clk) if (tbl_rd_en) tbl_rd_data <= mem[tbl_rd_addr];

  seg_xlate_unit i_seg_xlate_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_seg(req_seg),
    .req_disp(req_disp), .req_kind(req_kind), .tbl_base(tbl_base),
    .tbl_rd_en(tbl_rd_en), .tbl_rd_addr(tbl_rd_addr), .tbl_rd_data(tbl_rd_data),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_addr(rsp_addr)
  );

  function automatic logic [32:0] mk(input logic pres, input logic [3:0] perm,
                                     input logic [11:0] lim, input logic [15:0] b);
    return {pres, perm, lim, b};
  endfunction

  // Reference model written from the requirements.
  function automatic void predict(input logic [32:0] e, input logic [11:0] d,
                                  input logic [1:0] k, output logic [1:0] f,
                                  output logic [15:0] a);
    logic [16:0] sum;
    a = 16'h0000;
    if (e[32] == 1'b0)            f = 2'b01;
    else if (d > e[27:16])        f = 2'b10;
    else if (e[28 + int'(k)] == 1'b0) f = 2'b11;
    else begin
      f = 2'b00;
      sum = {1'b0, e[15:0]} + {5'b0, d};
      a = sum[15:0];
    end
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_rsp();
    if (pv[1]) begin
      check(rsp_valid == 1'b1, "R2", "rsp_valid", 32'(rsp_valid), 32'd1);
      check(rsp_fault == pf[1], pt[1], "rsp_fault", 32'(rsp_fault), 32'(pf[1]));
      check(rsp_addr == pa[1], (pf[1] != 2'b00) ? "R8" : pt[1], "rsp_addr",
            32'(rsp_addr), 32'(pa[1]));
    end else begin
      check(rsp_valid == 1'b0, "R2", "rsp_valid idle", 32'(rsp_valid), 32'd0);
      check((rsp_fault == 2'b00) && (rsp_addr == 16'h0), "R10", "idle outputs",
            {14'd0, rsp_fault, rsp_addr}, 32'd0);
    end
  endtask

  task automatic step(input logic v, input logic [3:0] s, input logic [11:0] d,
                      input logic [1:0] k, input string tag);
    logic [7:0]  idx;
    logic [1:0]  f;
    logic [15:0] a;
    @(negedge clk);
    check_rsp();
    idx = tbl_base + {4'b0, s};
    predict(mem[idx], d, k, f, a);
    pv[1] = pv[0]; pf[1] = pf[0]; pa[1] = pa[0]; pt[1] = pt[0];
    pv[0] = v;     pf[0] = f;     pa[0] = a;     pt[0] = tag;
    req_valid = v; req_seg = s; req_disp = d; req_kind = k;
    #1;
    check(tbl_rd_en == v, "R1", "tbl_rd_en", 32'(tbl_rd_en), 32'(v));
    if (v) check(tbl_rd_addr == idx, "R1", "tbl_rd_addr", 32'(tbl_rd_addr), 32'(idx));
  endtask

  task automatic drain();
    step(1'b0, 4'd0, 12'd0, 2'd0, "R10");
    step(1'b0, 4'd0, 12'd0, 2'd0, "R10");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 0; i < 2; i++) begin pv[i] = 1'b0; pf[i] = 2'b00; pa[i] = '0; pt[i] = "R10"; end

    // R9: outputs during reset
    repeat (3) @(negedge clk);
    check((rsp_valid == 1'b0) && (rsp_fault == 2'b00) && (rsp_addr == 16'h0), "R9",
          "reset outputs", {13'd0, rsp_valid, rsp_fault, rsp_addr}, 32'd0);
    rst_n = 1'b1;

    // Directed cases; origin near the top so the index wraps (R1).
    tbl_base = 8'hF8;
    mem[8'h02] = mk(1'b1, 4'b0001, 12'd100, 16'hFFF0);   // seg 10: read only
    mem[8'h03] = mk(1'b0, 4'b0000, 12'd0,   16'h1234);   // seg 11: absent
    mem[8'h04] = mk(1'b1, 4'b1111, 12'hFFF, 16'h0200);   // seg 12: all kinds
    mem[8'h05] = mk(1'b1, 4'b1010, 12'd50,  16'h1000);   // seg 13: write+append
    step(1'b1, 4'd10, 12'd100, 2'd0, "R5");  // bound edge, in range, address wraps (R3)
    step(1'b1, 4'd10, 12'd101, 2'd0, "R5");  // one past bound
    step(1'b1, 4'd10, 12'd7,   2'd1, "R6");  // write denied
    step(1'b1, 4'd10, 12'd101, 2'd1, "R7");  // overflow beats protection
    step(1'b1, 4'd11, 12'd5,   2'd1, "R7");  // missing beats overflow and protection
    step(1'b1, 4'd11, 12'd0,   2'd0, "R4");
    for (int k = 0; k < 4; k++) step(1'b1, 4'd12, 12'hFFF, 2'(k), "R3");
    step(1'b1, 4'd13, 12'd9,  2'd2, "R6");   // execute denied
    step(1'b1, 4'd13, 12'd50, 2'd3, "R6");   // append allowed
    step(1'b1, 4'd13, 12'd1,  2'd1, "R6");   // write allowed
    step(1'b1, 4'd13, 12'd1,  2'd0, "R6");   // read denied
    step(1'b0, 4'd13, 12'd1,  2'd0, "R2");   // gap
    step(1'b1, 4'd12, 12'd3,  2'd0, "R3");
    drain();

    // Constrained random phases.
    for (int ph = 0; ph < 6; ph++) begin
      tbl_base = 8'($urandom);
      for (int i = 0; i < 256; i++)
        mem[i] = mk(($urandom % 4) != 0, 4'($urandom), 12'($urandom), 16'($urandom));
      for (int n = 0; n < 500; n++) begin
        logic [3:0]  s;
        logic [11:0] d;
        logic [11:0] lim;
        s = 4'($urandom);
        lim = mem[8'(tbl_base + {4'b0, s})][27:16];
        if ($urandom % 2 == 0) d = lim + 12'($urandom % 3) - 12'd1;
        else d = 12'($urandom);
        step(($urandom % 5) != 0, s, d, 2'($urandom), "R3");
      end
      drain();
    end

    finish_run();
  end

endmodule